// File: doc/BRIEF.md
# Eight-line GPIO port with per-line interrupt sensing

This block is one general-purpose I/O port of eight lines behind a byte-wide register interface. Every line carries an output value bit and a drive-enable bit. When a line is an input, its pin is brought into the clock domain through a two-flop synchroniser and can optionally be filtered by a debouncer that advances on a slow sampling tick.

Each line is also an interrupt source. Two configuration bits per line choose level or edge sensing and the active polarity. An enable bit gates the source. Edge events are latched until software writes a one to that line's bit in the end-of-interrupt register. The port presents the pending state of all lines as a status byte, as eight separate interrupt outputs and as one combined request.

Software turns a line's enable off before it changes that line's sensing bits, then turns it back on. Read data is registered and appears one clock after the address is presented. Writes take effect on the clock edge on which `wr_en` is sampled high.

Top module: `gpio8_irq_port`

## Requirements
- R1: After a synchronous reset, every configuration register, every pending bit, `pin_out`, `pin_oe`, `irq_status`, `irq_line`, `irq_any` and `rdata` are 0.
- R2: `pin_out` equals the value register (address 0x00) and `pin_oe` equals the direction register (address 0x10), in which 1 drives the line. Reading 0x00 returns the value register bit for driven lines and the synchronised pin for the other lines.
- R3: The sensing-mode register (0x90), the polarity register (0x94), the enable register (0x9C) and the debounce register (0xA8) read back what was written. The end-of-interrupt address 0x98 reads as 0, and `rdata` follows the address presented in the previous cycle.
- R4: With a mode bit of 0 (level sensing), an enabled line's pending bit is 1 exactly while its qualified input equals its polarity bit (1 means high, 0 means low). This holds three clocks after a pin change when debounce is off.
- R5: With a mode bit of 1 (edge sensing), an enabled line's pending bit is set by a rising edge when its polarity bit is 1 and by a falling edge when it is 0. It then stays 1 through later changes of the input.
- R6: Writing a byte to 0x98 clears the latched edge of every line whose bit is 1. Bits written as 0 leave their lines unchanged, and the write has no effect on a level-sensed line.
- R7: A line whose enable bit is 0 has a pending bit of 0. An edge that arrives while the line is disabled is not latched, and it does not appear when the line is enabled again.
- R8: If an edge set and an end-of-interrupt clear reach the same line in the same cycle, the pending bit stays 1.
- R9: With a line's debounce bit at 1, its qualified input changes only after 4 consecutive `deb_tick` samples of the synchronised pin all differ from the current filtered level. A sample that matches the filtered level restarts the count.
- R10: `irq_line` equals `irq_status` bit for bit, and `irq_any` is 1 exactly when some status bit is 1.
- R11: Lines are independent: several lines can be pending at once, and each is reported in its own status bit.
- R12: The status register reads at 0xA0 and returns the pending bits. A write to 0xA0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data for the previous cycle's address |
| deb_tick | input | 1 | Slow sampling tick for the debouncers |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Output value per line |
| pin_oe | output | 8 | Drive enable per line (1 drives) |
| irq_status | output | 8 | Pending interrupt per line |
| irq_line | output | 8 | Individual interrupt outputs |
| irq_any | output | 1 | OR of all pending lines |

## Verification
On an edge-sensed line, a latched edge and an end-of-interrupt write can land in the same clock. The bench provokes this by raising the pin and placing the clearing write exactly on the cycle in which the synchronised edge reaches the latch. That cycle is two clocks after the first capture of the new pin level. The bench then expects the pending bit to survive, and a cycle-accurate behavioural model confirms the same outcome. During a long random phase, the model also judges every other collision of pin edges, configuration writes and clearing writes, clock by clock.

// File: rtl/gpio8_pkg.sv
package gpio8_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] A_VALUE  = 8'h00;
  localparam logic [ADDR_W-1:0] A_DIR    = 8'h10;
  localparam logic [ADDR_W-1:0] A_MODE   = 8'h90;
  localparam logic [ADDR_W-1:0] A_POL    = 8'h94;
  localparam logic [ADDR_W-1:0] A_CLEAR  = 8'h98;
  localparam logic [ADDR_W-1:0] A_ENABLE = 8'h9C;
  localparam logic [ADDR_W-1:0] A_STATUS = 8'hA0;
  localparam logic [ADDR_W-1:0] A_FILTER = 8'hA8;
endpackage

// File: rtl/gpio8_regs.sv
module gpio8_regs
  import gpio8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      value_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      mode_q,
  output logic [W-1:0]      pol_q,
  output logic [W-1:0]      en_q,
  output logic [W-1:0]      filt_q,
  output logic [W-1:0]      clear_mask
);
  always_ff @(posedge clk) begin
    if (rst) begin
      value_q <= '0;
      dir_q   <= '0;
      mode_q  <= '0;
      pol_q   <= '0;
      en_q    <= '0;
      filt_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        A_VALUE:  value_q <= wdata;
        A_DIR:    dir_q   <= wdata;
        A_MODE:   mode_q  <= wdata;
        A_POL:    pol_q   <= wdata;
        A_ENABLE: en_q    <= wdata;
        A_FILTER: filt_q  <= wdata;
        default: ;
      endcase
    end
  end

  assign clear_mask = (wr_en && addr == A_CLEAR) ? wdata : '0;
endmodule

// File: rtl/gpio8_sync.sv
module gpio8_sync #(
  parameter int W = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio8_debounce.sv
module gpio8_debounce #(
  parameter int W = 8,
  parameter int SAMPLES = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] raw,
  output logic [W-1:0] filt
);
  localparam int CW = (SAMPLES > 2) ? $clog2(SAMPLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SAMPLES - 1);

  for (genvar i = 0; i < W; i++) begin : g_line
    logic [CW-1:0] cnt;
    logic          lvl;
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt <= '0;
        lvl <= 1'b0;
      end else if (tick) begin
        if (raw[i] == lvl) begin
          cnt <= '0;
        end else if (cnt == LAST) begin
          lvl <= raw[i];
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
    assign filt[i] = lvl;
  end
endmodule

// File: rtl/gpio8_irq_core.sv
module gpio8_irq_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] qual,
  input  logic [W-1:0] mode,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] en,
  input  logic [W-1:0] clear_mask,
  output logic [W-1:0] pend,
  output logic         any,
  output logic [W-1:0] edge_hit
);
  logic [W-1:0] prev;
  logic [W-1:0] pend_nxt;

  for (genvar i = 0; i < W; i++) begin : g_line
    assign edge_hit[i] = pol[i] ? (qual[i] & ~prev[i]) : (~qual[i] & prev[i]);
    always_comb begin
      if (!en[i])              pend_nxt[i] = 1'b0;
      else if (!mode[i])       pend_nxt[i] = (qual[i] == pol[i]);
      else if (edge_hit[i])    pend_nxt[i] = 1'b1;
      else if (clear_mask[i])  pend_nxt[i] = 1'b0;
      else                     pend_nxt[i] = pend[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= '0;
      pend <= '0;
      any  <= 1'b0;
    end else begin
      prev <= qual;
      pend <= pend_nxt;
      any  <= |pend_nxt;
    end
  end
endmodule

// File: rtl/gpio8_irq_port.sv
module gpio8_irq_port
  import gpio8_pkg::*;
#(
  parameter int N_LINES = 8,
  parameter int DEB_SAMPLES = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              deb_tick,
  input  logic [7:0]        pin_in,
  output logic [7:0]        pin_out,
  output logic [7:0]        pin_oe,
  output logic [7:0]        irq_status,
  output logic [7:0]        irq_line,
  output logic              irq_any
);
  localparam int W = N_LINES;

  logic [W-1:0] value_q, dir_q, mode_q, pol_q, en_q, filt_q, clear_mask;
  logic [W-1:0] pin_sync, pin_filt, qual, pend, edge_hit;
  logic [W-1:0] rd_mux;

  gpio8_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata[W-1:0]),
    .value_q(value_q), .dir_q(dir_q), .mode_q(mode_q), .pol_q(pol_q),
    .en_q(en_q), .filt_q(filt_q), .clear_mask(clear_mask)
  );

  gpio8_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in[W-1:0]), .q(pin_sync)
  );

  gpio8_debounce #(.W(W), .SAMPLES(DEB_SAMPLES)) u_deb (
    .clk(clk), .rst(rst), .tick(deb_tick), .raw(pin_sync), .filt(pin_filt)
  );

  assign qual = (filt_q & pin_filt) | (~filt_q & pin_sync);

  gpio8_irq_core #(.W(W)) u_core (
    .clk(clk), .rst(rst), .qual(qual), .mode(mode_q), .pol(pol_q),
    .en(en_q), .clear_mask(clear_mask), .pend(pend), .any(irq_any),
    .edge_hit(edge_hit)
  );

  always_comb begin
    case (addr)
      A_VALUE:  rd_mux = (dir_q & value_q) | (~dir_q & pin_sync);
      A_DIR:    rd_mux = dir_q;
      A_MODE:   rd_mux = mode_q;
      A_POL:    rd_mux = pol_q;
      A_ENABLE: rd_mux = en_q;
      A_FILTER: rd_mux = filt_q;
      A_STATUS: rd_mux = pend;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= 8'(rd_mux);
  end

  assign pin_out    = 8'(value_q);
  assign pin_oe     = 8'(dir_q);
  assign irq_status = 8'(pend);
  assign irq_line   = 8'(pend);
endmodule

// File: rtl/gpio8_irq_chk.sv
module gpio8_irq_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] irq_status,
  input logic [7:0] irq_line,
  input logic       irq_any,
  input logic [7:0] en,
  input logic [7:0] mode,
  input logic [7:0] clr,
  input logic [7:0] hit
);
  // R10: combined request follows the status byte
  a_r10_any_or: assert property (@(posedge clk) disable iff (rst)
    irq_any == (irq_status != 8'h00));

  // R10: per-line outputs mirror the status
  a_r10_line_eq: assert property (@(posedge clk) disable iff (rst)
    irq_line == irq_status);

  // R7: a line disabled at the last edge is not pending
  a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((irq_status & ~$past(en)) == 8'h00));

  // R6: a clear on a quiet edge-sensed line empties it
  a_r6_clear_works: assert property (@(posedge clk) disable iff (rst)
    ((clr & mode & ~hit) != 8'h00) |=>
      ((irq_status & $past(clr & mode & ~hit)) == 8'h00));

  // R8: an edge on an enabled edge line always latches, even against a clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    ((hit & en & mode) != 8'h00) |=>
      ((irq_status & $past(hit & en & mode)) == $past(hit & en & mode)));
endmodule

bind gpio8_irq_port gpio8_irq_chk u_chk (
  .clk(clk), .rst(rst), .irq_status(irq_status), .irq_line(irq_line),
  .irq_any(irq_any), .en(en_q), .mode(mode_q), .clr(clear_mask), .hit(edge_hit)
);

// File: tb/tb_gpio8_irq_port.sv
module tb_gpio8_irq_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic       deb_tick = 1'b0;
  logic [7:0] pin_in = 8'h00;
  logic [7:0] rdata, pin_out, pin_oe, irq_status, irq_line;
  logic       irq_any;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  gpio8_irq_port dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .deb_tick(deb_tick), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq_status(irq_status), .irq_line(irq_line),
    .irq_any(irq_any)
  );

  // behavioural reference model, advanced once per rising edge
  logic [7:0] m_val, m_dir, m_mode, m_pol, m_en, m_filt;
  logic [7:0] m_s1, m_s2, m_lvl, m_prev, m_pend, m_rdata;
  int         m_cnt [8];

  function automatic logic [7:0] model_read(input logic [7:0] a);
    case (a)
      8'h00: return (m_dir & m_val) | (~m_dir & m_s2);
      8'h10: return m_dir;
      8'h90: return m_mode;
      8'h94: return m_pol;
      8'h9C: return m_en;
      8'hA8: return m_filt;
      8'hA0: return m_pend;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_val = 0; m_dir = 0; m_mode = 0; m_pol = 0; m_en = 0; m_filt = 0;
      m_s1 = 0; m_s2 = 0; m_lvl = 0; m_prev = 0; m_pend = 0; m_rdata = 0;
      for (int i = 0; i < 8; i++) m_cnt[i] = 0;
    end else begin
      logic [7:0] q, pend_n, clr, lvl_n;
      q = (m_filt & m_lvl) | (~m_filt & m_s2);
      clr = (wr_en && addr == 8'h98) ? wdata : 8'h00;
      lvl_n = m_lvl;
      for (int i = 0; i < 8; i++) begin
        bit rise, fall, hit;
        rise = q[i] && !m_prev[i];
        fall = !q[i] && m_prev[i];
        hit = m_pol[i] ? rise : fall;
        if (!m_en[i]) pend_n[i] = 0;
        else if (!m_mode[i]) pend_n[i] = (q[i] == m_pol[i]);
        else if (hit) pend_n[i] = 1;
        else if (clr[i]) pend_n[i] = 0;
        else pend_n[i] = m_pend[i];
        if (deb_tick) begin
          if (m_s2[i] == m_lvl[i]) m_cnt[i] = 0;
          else if (m_cnt[i] == 3) begin lvl_n[i] = m_s2[i]; m_cnt[i] = 0; end
          else m_cnt[i] = m_cnt[i] + 1;
        end
      end
      m_rdata = model_read(addr);
      m_prev = q;
      m_pend = pend_n;
      m_lvl = lvl_n;
      m_s2 = m_s1;
      m_s1 = pin_in;
      if (wr_en) begin
        case (addr)
          8'h00: m_val = wdata;
          8'h10: m_dir = wdata;
          8'h90: m_mode = wdata;
          8'h94: m_pol = wdata;
          8'h9C: m_en = wdata;
          8'hA8: m_filt = wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check8("R11 status vs model", irq_status, m_pend);
      check8("R10 irq_line vs status", irq_line, m_pend);
      check8("R10 irq_any vs model", {7'b0, irq_any}, {7'b0, m_pend != 0});
      check8("R2 pin_out vs model", pin_out, m_val);
      check8("R2 pin_oe vs model", pin_oe, m_dir);
      check8("R3 rdata vs model", rdata, m_rdata);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; addr = 8'h00; wdata = 8'h00;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick_pulse();
    @(negedge clk); deb_tick = 1'b1;
    @(negedge clk); deb_tick = 1'b0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check8("R1 status after reset", irq_status, 8'h00);
    check8("R1 pin_oe after reset", pin_oe, 8'h00);
    check8("R1 any after reset", {7'b0, irq_any}, 8'h00);
    rd(8'h9C, r); check8("R1 enable after reset", r, 8'h00);

    // R2 output drive and value readback
    wr(8'h10, 8'h0F); wr(8'h00, 8'hA5);
    pin_in = 8'h30; idle(3);
    check8("R2 pin_out", pin_out, 8'hA5);
    check8("R2 pin_oe", pin_oe, 8'h0F);
    rd(8'h00, r); check8("R2 value read mixes drive and pins", r, 8'h35);

    // R3 readback
    wr(8'h90, 8'h5A); rd(8'h90, r); check8("R3 mode readback", r, 8'h5A);
    wr(8'hA8, 8'h3C); rd(8'hA8, r); check8("R3 filter readback", r, 8'h3C);
    rd(8'h98, r); check8("R3 clear address reads zero", r, 8'h00);
    wr(8'hA8, 8'h00);

    // R4 level sensing: line0 active high, line1 active low
    pin_in = 8'h00;
    wr(8'h9C, 8'h00); wr(8'h90, 8'h00); wr(8'h94, 8'h01); wr(8'h9C, 8'h03);
    idle(4);
    check8("R4 low-level line pending", irq_status, 8'h02);
    pin_in = 8'h01; idle(4);
    check8("R4 both level lines pending", irq_status, 8'h03);
    wr(8'h98, 8'h03); idle(1);
    check8("R6 clear ignored in level mode", irq_status, 8'h03);
    pin_in = 8'h02; idle(4);
    check8("R4 level follows input", irq_status, 8'h00);

    // R5 edge sensing: lines 0-3 rising, 4-7 falling
    pin_in = 8'h00; idle(4);
    wr(8'h9C, 8'h00); wr(8'h90, 8'hFF); wr(8'h94, 8'h0F); wr(8'h9C, 8'hFF);
    idle(2);
    check8("R5 no edge yet", irq_status, 8'h00);
    pin_in = 8'h11; idle(4);
    check8("R5 rising edge latched", irq_status, 8'h01);
    pin_in = 8'h00; idle(4);
    check8("R11 two lines pending, R5 held", irq_status, 8'h11);

    // R6 clear
    wr(8'h98, 8'h01); idle(1);
    check8("R6 clear one line", irq_status, 8'h10);
    wr(8'h98, 8'h00); idle(1);
    check8("R6 zero bits no effect", irq_status, 8'h10);

    // R12 status readable, writes ignored
    wr(8'hA0, 8'h00); rd(8'hA0, r);
    check8("R12 status read after write", r, 8'h10);

    // R8 set and clear in the same cycle on line0
    @(negedge clk); pin_in = 8'h01;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; addr = 8'h98; wdata = 8'h01;
    @(negedge clk); wr_en = 1'b0; addr = 8'h00; wdata = 8'h00;
    check8("R8 set wins over clear", irq_status, 8'h11);
    wr(8'h98, 8'h11); idle(1);
    check8("R6 clear both", irq_status, 8'h00);

    // R7 disabled lines do not latch
    wr(8'h9C, 8'h00);
    pin_in = 8'h00; idle(4); pin_in = 8'h0F; idle(4);
    check8("R7 disabled no pending", irq_status, 8'h00);
    wr(8'h9C, 8'hFF); idle(3);
    check8("R7 no stale edge on enable", irq_status, 8'h00);

    // R9 debounce on line0, level high
    pin_in = 8'h00; idle(4);
    wr(8'h9C, 8'h00); wr(8'h90, 8'h00); wr(8'h94, 8'h01);
    wr(8'hA8, 8'h01); wr(8'h9C, 8'h01);
    idle(2);
    pin_in = 8'h01; idle(3);
    tick_pulse(); tick_pulse(); tick_pulse(); idle(3);
    check8("R9 three samples not enough", irq_status, 8'h00);
    pin_in = 8'h00; idle(3); tick_pulse(); pin_in = 8'h01; idle(3);
    tick_pulse(); tick_pulse(); tick_pulse(); idle(3);
    check8("R9 matching sample restarts count", irq_status, 8'h00);
    tick_pulse(); idle(3);
    check8("R9 fourth sample switches level", irq_status, 8'h01);

    // random phase, judged by the model each cycle
    for (int n = 0; n < 3000; n++) begin
      int k;
      @(negedge clk);
      k = $urandom_range(0, 9);
      if ($urandom_range(0, 3) == 0) pin_in = 8'($urandom);
      deb_tick = ($urandom_range(0, 2) == 0);
      if (k < 3) begin
        logic [7:0] al [8] = '{8'h00, 8'h10, 8'h90, 8'h94, 8'h98, 8'h9C, 8'hA8, 8'hA0};
        wr_en = 1'b1; addr = al[$urandom_range(0, 7)]; wdata = 8'($urandom);
      end else begin
        wr_en = 1'b0;
        addr = ($urandom_range(0, 1) == 0) ? 8'hA0 : 8'h00;
      end
    end
    @(negedge clk); wr_en = 1'b0; deb_tick = 1'b0;
    idle(2);
    finish_run();
  end
endmodule